// File: doc/BRIEF.md
# Sine Synthesizer with Start-Frequency and Start-Phase Offsets

This block is a numerically controlled sine source. A 16-bit phase accumulator advances once per enabled clock by an effective step. That step is the sum of a tuning word and a separate base-frequency word, so a sequencer that produces tuning words can sweep upward from a chosen starting frequency. The output frequency is step × f_clk / 2^16, which gives a resolution of f_clk / 2^16.

A start-phase word is added to the accumulated phase only on the way to the table. It moves the waveform in phase, but it never enters the accumulator. The ten most significant bits of that sum address a synthesizable sine table that covers one full cycle in 1024 points. The sample from the table is registered and leaves the block as a signed ten-bit value. A synchronous reset and a clock enable control the two register stages.

Top module: `sine_dds`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator clears to 0 and `sample` becomes 0 on that edge.
- R2: On each enabled edge, the accumulator advances by the effective step, modulo 2^16.
- R3: The effective step is (`tune_word` + `base_freq`) mod 2^16, so with `tune_word` at 0 the output still runs at the frequency that `base_freq` sets.
- R4: The table address is bits 15..6 of (accumulator + `start_phase`) mod 2^16. `start_phase` is never stored in the accumulator, so a constant `start_phase` with a zero step gives a constant output.
- R5: The table entry at address a is 511·sin(2π·a/1024), rounded half away from zero, so every `sample` lies in −511..+511.
- R6: `sample` is registered. The value produced at an enabled edge comes from the accumulator as it was just before that edge and from the `start_phase` present at that edge.
- R7: While `en` is low, neither the accumulator nor `sample` changes.
- R8: A step whose sum wraps past 2^16, and an accumulator that wraps past 2^16, both behave modulo 2^16 with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the accumulator and the output register |
| tune_word | input | 16 | Frequency tuning word |
| base_freq | input | 16 | Base-frequency word, added to the tuning word |
| start_phase | input | 16 | Phase offset, added after accumulation |
| sample | output | 10 | Registered sine sample, two's complement |

## Verification
The embedded properties check four things on every cycle: the accumulator's modulo-2^16 advance by tuning word plus base word, the freeze while the enable is low, the clearing under reset, and the ±511 bound on the output. Only the bench scenarios can show that the table contents are exact at every one of the 1024 addresses. The same holds for taking the upper ten address bits after the phase offset is added, the offset never accumulating, the wrap of an overflowing step sum, and the one-cycle alignment between phase and sample. The bench shows these through full address sweeps and randomized step, offset and enable sequences, all compared against a reference that it computes arithmetically.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int PHASE_W   = 16;
    localparam int ADDR_W    = 10;
    localparam int SAMPLE_W  = 10;
    localparam int AMPLITUDE = 511;

    localparam real TWO_PI = 2.0 * 3.14159265358979323846;

    typedef enum logic {
        ROM_FULL    = 1'b0,
        ROM_QUARTER = 1'b1
    } rom_kind_e;

    function automatic int round_away(input real x);
        if (x >= 0.0) begin
            return $rtoi(x + 0.5);
        end
        return -$rtoi(-x + 0.5);
    endfunction

endpackage

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
    parameter int PHASE_W = dds_pkg::PHASE_W,
    parameter int ADDR_W  = dds_pkg::ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] tune_word,
    input  logic [PHASE_W-1:0] base_freq,
    input  logic [PHASE_W-1:0] start_phase,
    output logic [ADDR_W-1:0]  rom_addr
);

    localparam int SHIFT = PHASE_W - ADDR_W;

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } acc_state_t;

    acc_state_t         st_d;
    acc_state_t         st_q;
    logic [PHASE_W-1:0] step_w;
    logic [PHASE_W-1:0] phase_w;

    always_comb begin
        step_w = tune_word + base_freq;
        st_d   = st_q;
        if (en) begin
            st_d.acc = st_q.acc + step_w;
        end
        phase_w  = st_q.acc + start_phase;
        rom_addr = ADDR_W'(phase_w >> SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1
    acc_reset_chk: assert property (@(posedge clk)
        rst |=> st_q.acc == '0);

    // R2 R3 R8
    acc_advance_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> st_q.acc == PHASE_W'($past(st_q.acc) + $past(tune_word) + $past(base_freq)));

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q.acc));

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
    parameter int                 ADDR_W    = dds_pkg::ADDR_W,
    parameter int                 SAMPLE_W  = dds_pkg::SAMPLE_W,
    parameter int                 AMPLITUDE = dds_pkg::AMPLITUDE,
    parameter dds_pkg::rom_kind_e KIND      = dds_pkg::ROM_QUARTER
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic signed [SAMPLE_W-1:0] value
);

    localparam int DEPTH   = 2 ** ADDR_W;
    localparam int QTR     = DEPTH / 4;
    localparam int QIDX_W  = ADDR_W - 2;
    localparam int MIRR_W  = ADDR_W - 1;

    generate
        if (KIND == dds_pkg::ROM_FULL) begin : g_full
            logic signed [SAMPLE_W-1:0] tbl [DEPTH];
            for (genvar i = 0; i < DEPTH; i++) begin : g_ent
                localparam int VAL = dds_pkg::round_away(
                    real'(AMPLITUDE) * $sin(dds_pkg::TWO_PI * real'(i) / real'(DEPTH)));
                assign tbl[i] = SAMPLE_W'(VAL);
            end
            always_comb begin
                value = tbl[addr];
            end
        end else begin : g_quarter
            logic signed [SAMPLE_W-1:0] tbl [QTR + 1];
            logic [QIDX_W-1:0]          idx;
            logic [1:0]                 quad;
            logic [MIRR_W-1:0]          fwd_idx;
            logic [MIRR_W-1:0]          rev_idx;
            logic [MIRR_W-1:0]          sel_idx;
            logic signed [SAMPLE_W-1:0] mag;
            for (genvar i = 0; i <= QTR; i++) begin : g_ent
                localparam int VAL = dds_pkg::round_away(
                    real'(AMPLITUDE) * $sin(dds_pkg::TWO_PI * real'(i) / real'(DEPTH)));
                assign tbl[i] = SAMPLE_W'(VAL);
            end
            always_comb begin
                quad    = addr[ADDR_W-1 -: 2];
                idx     = addr[QIDX_W-1:0];
                fwd_idx = MIRR_W'(idx);
                rev_idx = MIRR_W'(QTR) - MIRR_W'(idx);
                sel_idx = quad[0] ? rev_idx : fwd_idx;
                mag     = tbl[sel_idx];
                value   = quad[1] ? -mag : mag;
            end
        end
    endgenerate

endmodule

// File: rtl/sine_dds.sv
module sine_dds #(
    parameter int                 PHASE_W   = dds_pkg::PHASE_W,
    parameter int                 ADDR_W    = dds_pkg::ADDR_W,
    parameter int                 SAMPLE_W  = dds_pkg::SAMPLE_W,
    parameter int                 AMPLITUDE = dds_pkg::AMPLITUDE,
    parameter dds_pkg::rom_kind_e ROM_KIND  = dds_pkg::ROM_QUARTER
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic [PHASE_W-1:0]         tune_word,
    input  logic [PHASE_W-1:0]         base_freq,
    input  logic [PHASE_W-1:0]         start_phase,
    output logic signed [SAMPLE_W-1:0] sample
);

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] sample;
    } out_state_t;

    logic [ADDR_W-1:0]          rom_addr;
    logic signed [SAMPLE_W-1:0] rom_value;
    out_state_t                 out_d;
    out_state_t                 out_q;

    dds_phase_accum #(
        .PHASE_W (PHASE_W),
        .ADDR_W  (ADDR_W)
    ) accum_i (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .tune_word   (tune_word),
        .base_freq   (base_freq),
        .start_phase (start_phase),
        .rom_addr    (rom_addr)
    );

    dds_sine_rom #(
        .ADDR_W    (ADDR_W),
        .SAMPLE_W  (SAMPLE_W),
        .AMPLITUDE (AMPLITUDE),
        .KIND      (ROM_KIND)
    ) rom_i (
        .addr  (rom_addr),
        .value (rom_value)
    );

    always_comb begin
        out_d = out_q;
        if (en) begin
            out_d.sample = rom_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sample = out_q.sample;

    // R1
    out_reset_chk: assert property (@(posedge clk)
        rst |=> out_q.sample == '0);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(out_q.sample));

    // R5
    amp_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_q.sample >= -AMPLITUDE) && (out_q.sample <= AMPLITUDE));

endmodule

// File: tb/sine_dds_tb.sv
module sine_dds_tb_top;

    localparam real TWO_PI = 2.0 * 3.14159265358979323846;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic [15:0]       tune_word   = '0;
    logic [15:0]       base_freq   = '0;
    logic [15:0]       start_phase = '0;
    logic signed [9:0] sample;

    int     n_cmp   = 0;
    int     n_bad   = 0;
    int     cycles  = 0;
    string  tag     = "R1";

    logic [15:0] acc_m = '0;
    int          exp_s = 0;

    always #2 clk = ~clk;

    sine_dds dut_i (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .tune_word   (tune_word),
        .base_freq   (base_freq),
        .start_phase (start_phase),
        .sample      (sample)
    );

    function automatic int ref_sine(input int a);
        real x;
        x = 511.0 * $sin(TWO_PI * real'(a) / 1024.0);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    // Reference model built from the requirements
    always @(posedge clk) begin
        if (rst) begin
            acc_m <= '0;
            exp_s <= 0;
        end else if (en) begin
            exp_s <= ref_sine(int'(16'(acc_m + start_phase) >> 6));
            acc_m <= 16'(acc_m + tune_word + base_freq);
        end
    end

    task automatic cyc();
        @(negedge clk);
        cycles++;
        n_cmp++;
        if (int'(sample) != exp_s) begin
            n_bad++;
            $display("FAIL %s: sample=%0d expected=%0d at cycle %0d", tag, sample, exp_s, cycles);
        end
        if (int'(sample) > 511 || int'(sample) < -511) begin
            n_bad++;
            $display("FAIL R5: sample=%0d expected within -511..511", sample);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        run(2);
        rst = 1'b0;
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        do_reset();
        tag = "R1";
        en = 1'b0;
        run(3);

        // R5 R6: step of one address per clock sweeps every table entry in order
        tag = "R5";
        tune_word = 16'd64;
        en = 1'b1;
        run(1030);

        // R4: phase offset alone, all 1024 addresses, held output
        tag = "R4";
        do_reset();
        tag = "R4";
        tune_word = '0;
        base_freq = '0;
        en = 1'b1;
        for (int a = 0; a < 1024; a++) begin
            start_phase = 16'(a * 64 + (a % 64));
            run(3);
        end

        // R6: offset change appears on the very next sample
        tag = "R6";
        for (int k = 0; k < 40; k++) begin
            start_phase = 16'($urandom);
            run(1);
        end

        // R3: base word alone drives the frequency
        tag = "R3";
        do_reset();
        tag = "R3";
        start_phase = '0;
        tune_word = '0;
        base_freq = 16'd192;
        run(400);
        tune_word = 16'd100;
        base_freq = 16'd37;
        run(400);

        // R8: step sum wraps, accumulator wraps
        tag = "R8";
        tune_word = 16'hFFC0;
        base_freq = 16'h0080;
        run(300);
        tune_word = 16'h7FC1;
        base_freq = 16'h4A33;
        run(500);

        // R7: enable gating
        tag = "R7";
        for (int k = 0; k < 3000; k++) begin
            en = ($urandom % 3) != 0;
            if (k % 50 == 0) tune_word = 16'($urandom);
            if (k % 70 == 0) start_phase = 16'($urandom);
            run(1);
        end

        // R2: random steps and offsets
        tag = "R2";
        en = 1'b1;
        for (int k = 0; k < 20; k++) begin
            tune_word   = 16'($urandom);
            base_freq   = 16'($urandom);
            start_phase = 16'($urandom);
            run(200);
        end

        // R1: reset mid-run with enable low
        tag = "R1";
        en = 1'b0;
        rst = 1'b1;
        run(1);
        if (sample != 0) begin
            n_bad++;
            $display("FAIL R1: sample=%0d expected=0 after reset", sample);
        end
        n_cmp++;
        rst = 1'b0;
        en = 1'b1;
        start_phase = '0;
        run(20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule